// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block stores up to sixteen 8-bit characters and refreshes a multiplexed display from them. A scan counter walks a digit index through 8 or 16 positions, holding each for a fixed number of clock cycles. The byte at the current index goes out as two 4-bit nibbles, A (low half) and B (high half). A blanking strobe covers the first cycle of every digit period, so no digit lights while the digit index and the nibbles change.

Characters enter through a one-cycle write strobe. In left-entry order they fill successive positions from 0 upward. In right-entry order every write shifts the line one place toward position 0 and puts the new character in the last active position. A clear request fills the whole store with a selectable blanking code. Each nibble can be frozen (inhibit) or forced to the matching half of the blanking code (blank), with separate controls for A and B.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: After reset, digit_o is 0, nib_a_o and nib_b_o are 0, blank_o is 1, and all 16 stored characters are 0x00.
- R2: mode_i[0] selects the active digit count N (0: N=8, 1: N=16). digit_o steps 0,1,...,N-1,0,... and changes once every PERIOD cycles.
- R3: blank_o is 1 in exactly the first cycle of each digit period and 0 in its other PERIOD-1 cycles.
- R4: From the second cycle of a digit period on, nib_a_o shows bits [3:0] and nib_b_o shows bits [7:4] of the character stored at position digit_o, unless R9 or R10 applies.
- R5: With mode_i[1]=0 (left entry), a write stores wr_data_i at the write position, which starts at 0, advances by one per write and wraps to 0 after position N-1.
- R6: With mode_i[1]=1 (right entry), a write moves the character at position p to position p-1 for 1 <= p <= N-1, drops the one at position 0, and stores wr_data_i at position N-1.
- R7: A cycle with clr_i=1 fills all 16 positions with the blanking code and returns the left-entry write position to 0. A write in the same cycle is dropped.
- R8: The blanking code follows code_sel_i: 00 and 01 give 0x00, 10 gives 0x20, 11 gives 0xFF.
- R9: While inh_a_i (inh_b_i) is 1 and the matching blank input is 0, nib_a_o (nib_b_o) keeps its value. When inhibit is released, the nibble follows R4 again.
- R10: While blk_a_i is 1, nib_a_o equals bits [3:0] of the blanking code. While blk_b_i is 1, nib_b_o equals bits [7:4]. Blank takes priority over inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0: 16 digits (1) or 8 digits (0). Bit 1: right entry (1) or left entry (0) |
| wr_en_i | input | 1 | Character write strobe, one write per cycle high |
| wr_data_i | input | 8 | Character to write |
| clr_i | input | 1 | Fill the store with the blanking code |
| code_sel_i | input | 2 | Blanking code select |
| inh_a_i | input | 1 | Freeze nibble A |
| inh_b_i | input | 1 | Freeze nibble B |
| blk_a_i | input | 1 | Force nibble A to the blanking code |
| blk_b_i | input | 1 | Force nibble B to the blanking code |
| digit_o | output | 4 | Current digit index |
| nib_a_o | output | 4 | Low nibble of the current character |
| nib_b_o | output | 4 | High nibble of the current character |
| blank_o | output | 1 | Digit blanking strobe |

## Verification
The assertions check these on every cycle: the digit index only moves forward by one or wraps to zero, and only in a blanked cycle. Blanking pulses are exactly PERIOD cycles apart. A frozen nibble holds its value. A blanked nibble carries the selected code half. The bench scenarios cover what the ports show only through the scan, such as where a write landed, the shifting in right-entry order, the pointer wrap, the contents after a clear, and the clear winning over a same-cycle write. The bench reads back a full frame of the scan to check each of these.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;
  localparam int CHAR_W = 8;
  localparam int NIB_W  = CHAR_W / 2;

  function automatic logic [CHAR_W-1:0] blank_code(input logic [1:0] sel);
    unique case (sel)
      2'b10:   blank_code = 8'h20;
      2'b11:   blank_code = 8'hFF;
      default: blank_code = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int DEPTH  = 16,
  parameter int PERIOD = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  output logic [IDX_W-1:0] digit_o,
  output logic             first_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] digit_q;
  logic [IDX_W-1:0] last;

  assign last = wide_i ? IDX_W'(DEPTH - 1) : IDX_W'(DEPTH / 2 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      digit_q <= '0;
    end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
      cnt_q   <= '0;
      digit_q <= (digit_q >= last) ? '0 : digit_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign digit_o = digit_q;
  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/disp_store.sv
module disp_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              right_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] fill_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wptr_q;
  logic [IDX_W-1:0]  last;
  logic              wr_left, wr_right;

  assign last     = wide_i ? IDX_W'(DEPTH - 1) : IDX_W'(DEPTH / 2 - 1);
  assign wr_left  = wr_en_i && !right_i && !clr_i;
  assign wr_right = wr_en_i &&  right_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wptr_q <= '0;
    else if (clr_i)   wptr_q <= '0;
    else if (wr_left) wptr_q <= (wptr_q >= last) ? '0 : wptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] q_r, nxt;

    if (g == DEPTH - 1) begin : g_top
      always_comb begin
        nxt = q_r;
        if (clr_i)                                     nxt = fill_i;
        else if (wr_right && last == IDX_W'(g))        nxt = wr_data_i;
        else if (wr_left && wptr_q == IDX_W'(g))       nxt = wr_data_i;
      end
    end else begin : g_low
      always_comb begin
        nxt = q_r;
        if (clr_i)                                     nxt = fill_i;
        else if (wr_right && last == IDX_W'(g))        nxt = wr_data_i;
        else if (wr_right && IDX_W'(g) < last)         nxt = mem[g+1];
        else if (wr_left && wptr_q == IDX_W'(g))       nxt = wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= nxt;
    end

    assign mem[g] = q_r;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/disp_nibble.sv
module disp_nibble #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] fill_i,
  input  logic         inh_i,
  input  logic         blk_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (blk_i)  q_o <= fill_i;
    else if (!inh_i) q_o <= src_i;
  end
endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
  import disp_refresh_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PERIOD = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [1:0]        code_sel_i,
  input  logic              inh_a_i,
  input  logic              inh_b_i,
  input  logic              blk_a_i,
  input  logic              blk_b_i,
  output logic [IDX_W-1:0]  digit_o,
  output logic [NIB_W-1:0]  nib_a_o,
  output logic [NIB_W-1:0]  nib_b_o,
  output logic              blank_o
);
  logic [CHAR_W-1:0] fill, cur_char;
  logic [1:0]        inh_v, blk_v;
  logic [NIB_W-1:0]  nib_q [2];

  assign fill  = blank_code(code_sel_i);
  assign inh_v = {inh_b_i, inh_a_i};
  assign blk_v = {blk_b_i, blk_a_i};

  disp_scan #(.DEPTH(DEPTH), .PERIOD(PERIOD)) scan_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (mode_i[0]),
    .digit_o (digit_o),
    .first_o (blank_o)
  );

  disp_store #(.DEPTH(DEPTH), .DATA_W(CHAR_W)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wide_i    (mode_i[0]),
    .right_i   (mode_i[1]),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_i     (clr_i),
    .fill_i    (fill),
    .rd_idx_i  (digit_o),
    .rd_data_o (cur_char)
  );

  for (genvar n = 0; n < 2; n++) begin : g_nib
    disp_nibble #(.W(NIB_W)) nib_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (cur_char[n*NIB_W +: NIB_W]),
      .fill_i (fill[n*NIB_W +: NIB_W]),
      .inh_i  (inh_v[n]),
      .blk_i  (blk_v[n]),
      .q_o    (nib_q[n])
    );
  end

  assign nib_a_o = nib_q[0];
  assign nib_b_o = nib_q[1];
endmodule

// File: rtl/disp_refresh_ctrl_chk.sv
module disp_refresh_ctrl_chk
  import disp_refresh_pkg::*;
#(
  parameter int PERIOD = 4,
  parameter int IDX_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       code_sel_i,
  input logic             inh_a_i,
  input logic             inh_b_i,
  input logic             blk_a_i,
  input logic             blk_b_i,
  input logic [IDX_W-1:0] digit_o,
  input logic [NIB_W-1:0] nib_a_o,
  input logic [NIB_W-1:0] nib_b_o,
  input logic             blank_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (blank_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  AST_DIGIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_o != $past(digit_o)) |-> (digit_o == '0 || digit_o == IDX_W'($past(digit_o) + 1'b1))); // R2
  AST_DIGIT_MOVE_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_o != $past(digit_o)) |-> blank_o); // R3
  AST_BLANK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && seen_q) |-> (gap_q == 32'(PERIOD - 1))); // R3
  AST_INHIBIT_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_a_i && !blk_a_i) |=> (nib_a_o == $past(nib_a_o))); // R9
  AST_INHIBIT_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_b_i && !blk_b_i) |=> (nib_b_o == $past(nib_b_o))); // R9
  AST_BLANK_A_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_a_i |=> (nib_a_o == blank_code($past(code_sel_i))[NIB_W-1:0])); // R10
  AST_BLANK_B_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_b_i |=> (nib_b_o == blank_code($past(code_sel_i))[2*NIB_W-1:NIB_W])); // R10
endmodule

bind disp_refresh_ctrl disp_refresh_ctrl_chk #(.PERIOD(PERIOD), .IDX_W(IDX_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_sel_i (code_sel_i),
  .inh_a_i    (inh_a_i),
  .inh_b_i    (inh_b_i),
  .blk_a_i    (blk_a_i),
  .blk_b_i    (blk_b_i),
  .digit_o    (digit_o),
  .nib_a_o    (nib_a_o),
  .nib_b_o    (nib_b_o),
  .blank_o    (blank_o)
);

// File: tb/disp_refresh_ctrl_tb_top.sv
module disp_refresh_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 4;
  localparam int NVEC       = 12;
  // {mode[1:0], data[7:0], expected position[3:0]}
  localparam logic [13:0] VECS [NVEC] = '{
    {2'b00, 8'h11, 4'd0}, {2'b00, 8'h22, 4'd1}, {2'b00, 8'h33, 4'd2},
    {2'b00, 8'h44, 4'd3}, {2'b00, 8'h55, 4'd4}, {2'b00, 8'h66, 4'd5},
    {2'b00, 8'h77, 4'd6}, {2'b00, 8'h88, 4'd7}, {2'b00, 8'h99, 4'd0},
    {2'b11, 8'hA1, 4'd15}, {2'b11, 8'hB2, 4'd15}, {2'b11, 8'hC3, 4'd15}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       clr_i = 1'b0;
  logic [1:0] code_sel_i = 2'b00;
  logic       inh_a_i = 1'b0, inh_b_i = 1'b0, blk_a_i = 1'b0, blk_b_i = 1'b0;
  logic [3:0] digit_o, nib_a_o, nib_b_o;
  logic       blank_o;

  int   n_run = 0, n_fail = 0;
  logic [7:0] img [16];
  bit   seq_err, blk_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_refresh_ctrl #(.DEPTH(16), .PERIOD(DWELL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .clr_i(clr_i), .code_sel_i(code_sel_i),
    .inh_a_i(inh_a_i), .inh_b_i(inh_b_i), .blk_a_i(blk_a_i), .blk_b_i(blk_b_i),
    .digit_o(digit_o), .nib_a_o(nib_a_o), .nib_b_o(nib_b_o), .blank_o(blank_o)
  );

  function automatic logic [7:0] exp_code(input logic [1:0] s);
    if (s == 2'b11) return 8'hFF;
    if (s == 2'b10) return 8'h20;
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // read one frame of the scan into img, flagging sequence and blanking errors
  task automatic grab(input int n);
    int prev;
    seq_err = 0;
    blk_err = 0;
    prev = -1;
    @(negedge clk);
    while (!blank_o) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (blank_o) blk_err = 1;
      if (prev >= 0 && int'(digit_o) != (prev + 1) % n) seq_err = 1;
      prev = int'(digit_o);
      img[digit_o] = {nib_b_o, nib_a_o};
      repeat (DWELL - 1) @(negedge clk);
      if (!blank_o) blk_err = 1;
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_clear(input logic [1:0] s);
    @(negedge clk);
    code_sel_i = s;
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    logic [3:0] held;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check(digit_o == 4'd0, "R1", "digit after reset", 32'(digit_o), 0);
    check(nib_a_o == 4'd0 && nib_b_o == 4'd0, "R1", "nibbles after reset",
          {24'd0, nib_b_o, nib_a_o}, 0);
    check(blank_o == 1'b1, "R1", "blank after reset", 32'(blank_o), 1);
    grab(8);
    ok = 1;
    for (int i = 0; i < 8; i++) if (img[i] != 8'h00) ok = 0;
    check(ok, "R1", "store contents after reset", 32'(img[0]), 0);
    // R2 R3 in 8-digit mode
    check(!seq_err, "R2", "8-digit scan order", 32'(seq_err), 0);
    check(!blk_err, "R3", "8-digit blank timing", 32'(blk_err), 0);

    // table walk: R5 left entry with wrap, R6 right entry tail position, R4 readout
    for (int i = 0; i < NVEC; i++) begin
      if (i == 0 || VECS[i][13:12] != VECS[i-1][13:12]) begin
        @(negedge clk);
        mode_i = VECS[i][13:12];
        do_clear(2'b00);
      end
      do_write(VECS[i][11:4]);
      grab(VECS[i][12] ? 16 : 8);
      check(img[VECS[i][3:0]] == VECS[i][11:4], VECS[i][13] ? "R6" : "R5",
            "character at entry position", 32'(img[VECS[i][3:0]]), 32'(VECS[i][11:4]));
    end
    // R6 earlier characters shifted toward position 0
    check(img[14] == 8'hB2, "R6", "shifted once", 32'(img[14]), 32'hB2);
    check(img[13] == 8'hA1, "R6", "shifted twice", 32'(img[13]), 32'hA1);
    check(!seq_err, "R2", "16-digit scan order", 32'(seq_err), 0);
    check(!blk_err, "R3", "16-digit blank timing", 32'(blk_err), 0);

    // R7 R8 clear fills with each code
    for (int s = 0; s < 4; s++) begin
      do_clear(2'(s));
      grab(16);
      ok = 1;
      for (int i = 0; i < 16; i++) if (img[i] != exp_code(2'(s))) ok = 0;
      check(ok, "R8", "clear code fill", 32'(img[5]), 32'(exp_code(2'(s))));
    end

    // R7 clear wins over same-cycle write, pointer back to 0
    @(negedge clk);
    mode_i = 2'b01;
    do_write(8'h01);
    do_write(8'h02);
    @(negedge clk);
    code_sel_i = 2'b11;
    clr_i = 1'b1;
    wr_en_i = 1'b1;
    wr_data_i = 8'h5A;
    @(negedge clk);
    clr_i = 1'b0;
    wr_en_i = 1'b0;
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i] != 8'hFF) ok = 0;
    check(ok, "R7", "clear beats write", 32'(img[2]), 32'hFF);
    do_write(8'h77);
    grab(16);
    check(img[0] == 8'h77 && img[2] == 8'hFF, "R7", "pointer reset by clear",
          32'(img[0]), 32'h77);

    // load distinct nibbles, 16-digit left entry
    do_clear(2'b00);
    for (int i = 0; i < 16; i++) do_write({4'(15 - i), 4'(i)});
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i] != {4'(15 - i), 4'(i)}) ok = 0;
    check(ok, "R4", "nibble split of each character", 32'(img[3]), 32'hC3);

    // R9 inhibit A freezes A, B keeps scanning
    @(negedge clk);
    inh_a_i = 1'b1;
    held = nib_a_o;
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i][3:0] != held) ok = 0;
    check(ok, "R9", "nibble A frozen", 32'(img[7][3:0]), 32'(held));
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i][7:4] != 4'(15 - i)) ok = 0;
    check(ok, "R9", "nibble B unaffected", 32'(img[7][7:4]), 32'd8);
    @(negedge clk);
    inh_a_i = 1'b0;
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i][3:0] != 4'(i)) ok = 0;
    check(ok, "R9", "nibble A restored", 32'(img[7][3:0]), 32'd7);

    // R10 blanking per nibble with code 0x20
    @(negedge clk);
    code_sel_i = 2'b10;
    blk_a_i = 1'b1;
    blk_b_i = 1'b1;
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i] != 8'h20) ok = 0;
    check(ok, "R10", "both nibbles blanked to 0x20", 32'(img[9]), 32'h20);
    // R10 blank over inhibit
    @(negedge clk);
    blk_b_i = 1'b0;
    inh_a_i = 1'b1;
    code_sel_i = 2'b11;
    grab(16);
    ok = 1;
    for (int i = 0; i < 16; i++) if (img[i][3:0] != 4'hF) ok = 0;
    check(ok, "R10", "blank beats inhibit", 32'(img[4][3:0]), 32'hF);
    check(img[4][7:4] == 4'd11, "R4", "unblanked nibble B", 32'(img[4][7:4]), 32'd11);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule